// File: doc/BRIEF.md
# Multiplexed Address Memory Bus Controller

This block runs memory cycles for an 8-bit processor core over a narrow external bus. The core hands over one read or write request at a time: a 16-bit address and, for a write, a data byte. The block sends the address over 8 shared pins. When the upper byte is needed, it goes out first while a strobe marks it so that external logic can latch it. The lower byte follows. The block then drives the active-low read enable or write strobe. It finishes each access with a one-cycle done pulse, and for a read it also returns the captured data byte.

The block keeps a copy of the upper address byte it last put on the pins. When the next access uses the same upper byte, the strobe phase is left out and the access finishes one cycle earlier. The write strobe can take one of three shapes. The read and write signals can each be gated off while the upper-byte strobe is active. The data bus is split into an output byte, an input byte and an output-enable, so the pad ring can build the bidirectional pins.

Top module: `membus_mux`

## Requirements
- R1: While reset is held, and in the first cycle after it, hi_strobe is 0, rd_n is 1, wr_n is 1, bus_oe is 0, done is 0 and req_ready is 1.
- R2: After reset the stored upper byte is invalid, so the first accepted request has an upper phase. This is one cycle with hi_strobe=1 and addr_pins=addr[15:8]. It is followed by one access cycle with hi_strobe=0 and addr_pins=addr[7:0].
- R3: When a request's addr[15:8] equals the upper byte last emitted, there is no upper phase. The access cycle comes in the first cycle after acceptance, and done is high in the second cycle. With an upper phase, done is high in the third cycle.
- R4: When a request's upper byte differs from the stored one, the upper phase is emitted again and the stored byte becomes the new value.
- R5: During a read, rd_n is 0 in the upper phase (when not gated) and in the access cycle. At the clock edge that ends the access cycle, rdata takes the value on bus_din. done is high for exactly one cycle after that edge, and rdata then holds its value.
- R6: bus_oe is 1, and bus_dout equals the write byte, only during the access cycle of a write. bus_oe is 0 during reads and during upper phases.
- R7: During a write access cycle, wr_shape selects the shape of wr_n. With 0 or 3 it is low for the whole cycle. With 1 it is low only while clk is low. With 2 it is low only while clk is high.
- R8: With rd_gate_en=1, rd_n is 1 whenever hi_strobe is 1.
- R9: With wr_gate_en=1, wr_n is 1 whenever hi_strobe is 1.
- R10: A request is accepted only when req_ready is 1. A req_valid pulse while an access is in progress starts no access and leaves the stored upper byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request pulse from the core |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| wr_shape | input | 2 | Write strobe shape select |
| rd_gate_en | input | 1 | Hold rd_n inactive while hi_strobe is active |
| wr_gate_en | input | 1 | Hold wr_n inactive while hi_strobe is active |
| bus_din | input | 8 | Data bus input byte |
| req_ready | output | 1 | Block is idle and can accept a request |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 8 | Captured read byte |
| addr_pins | output | 8 | Multiplexed address byte |
| hi_strobe | output | 1 | Marks the upper address byte on addr_pins |
| rd_n | output | 1 | Read enable, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 8 | Data bus output byte |

## Verification
The bench checks that an access always has an upper phase after reset. A design that trusted a stale cached byte would drive the lower byte first and end one cycle early. The bench then alternates matching and changing upper bytes, so a cache that never refreshes, or refreshes on the wrong request, shows up as a missing or an extra strobe cycle. The write strobe is sampled in both clock halves for every shape, which catches swapped or unshaped modes. The gate settings are checked during the strobe. A request pulse sent mid-access must neither start a second access nor spoil the cached byte that a later skip depends on.

// File: rtl/membus_pkg.sv
// Package: shared types and encodings for the multiplexed memory bus controller.
// Assumes a single clock domain; all users import this package.
package membus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_XFER = 2'd2
    } bus_state_t;

    localparam logic [1:0] SHAPE_FULL     = 2'd0;
    localparam logic [1:0] SHAPE_LOW_HALF = 2'd1;
    localparam logic [1:0] SHAPE_HIGH_HALF = 2'd2;

endpackage

// File: rtl/membus_seq.sv
// Module: access sequencer. Accepts one request at a time, decides whether
// the upper-byte phase is needed from a cached copy of the last emitted
// upper byte, steps through the phases and captures read data.
// Assumes req_valid is only acted on in the idle state.
module membus_seq
    import membus_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [PW-1:0] req_wdata,
    input  logic [PW-1:0] bus_din,
    output bus_state_t    state,
    output logic          op_write,
    output logic [PW-1:0] addr_hi,
    output logic [PW-1:0] addr_lo,
    output logic [PW-1:0] wdata_q,
    output logic [PW-1:0] rdata,
    output logic          done
);

    localparam int HW = AW - PW;

    logic [HW-1:0] hi_last;
    logic          hi_valid;
    logic          hi_hit;
    logic          accept;

    // Purpose: the upper byte of the new request matches the cached one.
    assign hi_hit = hi_valid && (req_addr[AW-1:PW] == hi_last);
    assign accept = (state == ST_IDLE) && req_valid;

    // Purpose: phase sequencing, request latch, upper-byte cache and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_write <= 1'b0;
            addr_hi  <= '0;
            addr_lo  <= '0;
            wdata_q  <= '0;
            rdata    <= '0;
            done     <= 1'b0;
            hi_last  <= '0;
            hi_valid <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_write <= req_write;
                        addr_hi  <= req_addr[AW-1:PW];
                        addr_lo  <= req_addr[PW-1:0];
                        wdata_q  <= req_wdata;
                        state    <= hi_hit ? ST_XFER : ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    hi_last  <= addr_hi;
                    hi_valid <= 1'b1;
                    state    <= ST_XFER;
                end
                ST_XFER: begin
                    if (!op_write) begin
                        rdata <= bus_din;
                    end
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SKIP_ON_HIT:  assert property (@(posedge clk) disable iff (!rst_n)
        accept && hi_hit |=> state == ST_XFER);                    // R3
    AST_HIGH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !hi_hit |=> state == ST_HIGH);                   // R4
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R5
    AST_BUSY_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HIGH |=> state == ST_XFER);                    // R10

endmodule

// File: rtl/membus_strobe.sv
// Module: strobe shaping. Builds the active-low read enable and write
// strobe plus the data-bus output enable from the current phase.
// Assumes the write shape is applied against the live clock level.
module membus_strobe
    import membus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_t state,
    input  logic       op_write,
    input  logic [1:0] wr_shape,
    input  logic       rd_gate_en,
    input  logic       wr_gate_en,
    output logic       hi_strobe,
    output logic       rd_n,
    output logic       wr_n,
    output logic       bus_oe
);

    logic rd_phase;
    logic wr_phase;
    logic wr_shaped;

    // Purpose: decode phase flags from the sequencer state.
    always_comb begin
        hi_strobe = (state == ST_HIGH);
        rd_phase  = !op_write && (state == ST_HIGH || state == ST_XFER);
        wr_phase  = op_write && (state == ST_XFER);
    end

    // Purpose: apply the selected write strobe shape.
    always_comb begin
        unique case (wr_shape)
            SHAPE_LOW_HALF:  wr_shaped = wr_phase && !clk;
            SHAPE_HIGH_HALF: wr_shaped = wr_phase && clk;
            default:         wr_shaped = wr_phase;
        endcase
    end

    // Purpose: optional gating by the upper-byte strobe, active-low outputs.
    always_comb begin
        rd_n   = !(rd_phase && !(rd_gate_en && hi_strobe));
        wr_n   = !(wr_shaped && !(wr_gate_en && hi_strobe));
        bus_oe = wr_phase;
    end

    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> rd_n);                                          // R6
    AST_OE_NOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hi_strobe |-> !bus_oe);                                    // R6

endmodule

// File: rtl/membus_mux.sv
// Module: top of the multiplexed-address memory bus controller.
// Puts the upper or lower address byte on the shared pins, exposes the
// strobes and data bus controls, and returns read data with a done pulse.
// Assumes AW is exactly twice PW.
module membus_mux
    import membus_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [PW-1:0] req_wdata,
    input  logic [1:0]    wr_shape,
    input  logic          rd_gate_en,
    input  logic          wr_gate_en,
    input  logic [PW-1:0] bus_din,
    output logic          req_ready,
    output logic          done,
    output logic [PW-1:0] rdata,
    output logic [PW-1:0] addr_pins,
    output logic          hi_strobe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          bus_oe,
    output logic [PW-1:0] bus_dout
);

    bus_state_t    state;
    logic          op_write;
    logic [PW-1:0] addr_hi;
    logic [PW-1:0] addr_lo;
    logic [PW-1:0] wdata_q;

    membus_seq #(.AW(AW), .PW(PW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_din   (bus_din),
        .state     (state),
        .op_write  (op_write),
        .addr_hi   (addr_hi),
        .addr_lo   (addr_lo),
        .wdata_q   (wdata_q),
        .rdata     (rdata),
        .done      (done)
    );

    membus_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .op_write   (op_write),
        .wr_shape   (wr_shape),
        .rd_gate_en (rd_gate_en),
        .wr_gate_en (wr_gate_en),
        .hi_strobe  (hi_strobe),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_oe     (bus_oe)
    );

    // Purpose: address byte select and ready flag.
    always_comb begin
        addr_pins = hi_strobe ? addr_hi : addr_lo;
        bus_dout  = wdata_q;
        req_ready = (state == ST_IDLE);
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_strobe |=> !hi_strobe);                                 // R2
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gate_en && hi_strobe |-> rd_n);                         // R8
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate_en && hi_strobe |-> wr_n);                         // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> $stable(rdata));                           // R5

endmodule

// File: tb/membus_mux_bench.sv
// Directed bench for membus_mux: one task per scenario, each checking itself.
module membus_mux_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  wr_shape = 2'd0;
    logic        rd_gate_en = 1'b0;
    logic        wr_gate_en = 1'b0;
    logic [7:0]  bus_din = '0;
    logic        req_ready, done, hi_strobe, rd_n, wr_n, bus_oe;
    logic [7:0]  rdata, addr_pins, bus_dout;

    int n_checks = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membus_mux u_membus_mux (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wr_shape(wr_shape),
        .rd_gate_en(rd_gate_en), .wr_gate_en(wr_gate_en), .bus_din(bus_din),
        .req_ready(req_ready), .done(done), .rdata(rdata), .addr_pins(addr_pins),
        .hi_strobe(hi_strobe), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe),
        .bus_dout(bus_dout)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected wr_n in each clock half for a write access cycle (R7).
    function automatic logic wr_exp(input logic [1:0] shape, input logic high_half);
        case (shape)
            2'd1: return high_half;
            2'd2: return !high_half;
            default: return 1'b0;
        endcase
    endfunction

    // One access, checked phase by phase.
    task automatic do_access(input logic wr, input logic [15:0] addr, input logic [7:0] data,
                             input logic exp_hi, input logic [1:0] shape,
                             input logic rg, input logic wg);
        @(negedge clk); #1;
        wr_shape = shape; rd_gate_en = rg; wr_gate_en = wg;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        if (!wr) bus_din = data;
        chk("R10 ready before request", {15'd0, req_ready}, 16'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (exp_hi) begin
            chk("R2 strobe in upper phase", {15'd0, hi_strobe}, 16'd1);
            chk("R2 upper byte on pins", {8'd0, addr_pins}, {8'd0, addr[15:8]});
            chk("R6 no drive in upper phase", {15'd0, bus_oe}, 16'd0);
            if (!wr) chk(rg ? "R8 rd gated" : "R5 rd in upper phase",
                         {15'd0, rd_n}, rg ? 16'd1 : 16'd0);
            if (wg) chk("R9 wr gated", {15'd0, wr_n}, 16'd1);
            @(posedge clk); #1;
        end else begin
            chk("R3 no strobe on hit", {15'd0, hi_strobe}, 16'd0);
        end
        if (wr) chk("R7 wr_n high half", {15'd0, wr_n}, {15'd0, wr_exp(shape, 1'b1)});
        @(negedge clk); #1;
        chk("R2 lower byte on pins", {8'd0, addr_pins}, {8'd0, addr[7:0]});
        chk("R3 no done in access", {15'd0, done}, 16'd0);
        if (wr) begin
            chk("R6 bus driven", {15'd0, bus_oe}, 16'd1);
            chk("R6 write byte", {8'd0, bus_dout}, {8'd0, data});
            chk("R7 wr_n low half", {15'd0, wr_n}, {15'd0, wr_exp(shape, 1'b0)});
        end else begin
            chk("R5 rd_n in access", {15'd0, rd_n}, 16'd0);
            chk("R6 no drive on read", {15'd0, bus_oe}, 16'd0);
            chk("R5 wr_n idle on read", {15'd0, wr_n}, 16'd1);
        end
        @(posedge clk); #1;
        bus_din = 8'hEE;
        chk("R3 done timing", {15'd0, done}, 16'd1);
        chk("R5 rd_n released", {15'd0, rd_n}, 16'd1);
        if (!wr) chk("R5 rdata", {8'd0, rdata}, {8'd0, data});
        @(posedge clk); #1;
        chk("R5 done single cycle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 hi_strobe", {15'd0, hi_strobe}, 16'd0);
        chk("R1 rd_n", {15'd0, rd_n}, 16'd1);
        chk("R1 wr_n", {15'd0, wr_n}, 16'd1);
        chk("R1 bus_oe", {15'd0, bus_oe}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 ready", {15'd0, req_ready}, 16'd1);
    endtask

    task automatic t_reads();
        do_access(1'b0, 16'h1234, 8'hA5, 1'b1, 2'd0, 1'b0, 1'b0); // R2 first access
        do_access(1'b0, 16'h1256, 8'h3C, 1'b0, 2'd0, 1'b0, 1'b0); // R3 skip
    endtask

    task automatic t_writes();
        do_access(1'b1, 16'h3A7C, 8'h81, 1'b1, 2'd0, 1'b0, 1'b0); // R4 new upper
        do_access(1'b1, 16'h3A01, 8'h42, 1'b0, 2'd1, 1'b0, 1'b0); // R7 low half
        do_access(1'b1, 16'h3A02, 8'h24, 1'b0, 2'd2, 1'b0, 1'b0); // R7 high half
        do_access(1'b1, 16'h3A03, 8'h18, 1'b0, 2'd3, 1'b0, 1'b0); // R7 code 3 full
    endtask

    task automatic t_gates();
        do_access(1'b0, 16'h5510, 8'h66, 1'b1, 2'd0, 1'b1, 1'b0); // R8
        do_access(1'b1, 16'h6620, 8'h99, 1'b1, 2'd0, 1'b0, 1'b1); // R9
    endtask

    task automatic t_busy_ignore();
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7001; bus_din = 8'h5A;
        @(posedge clk); #1;
        req_addr = 16'h9902;                    // R10 request while busy
        chk("R10 not ready while busy", {15'd0, req_ready}, 16'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R10 first access done", {15'd0, done}, 16'd1);
        @(posedge clk); #1;
        chk("R10 no second strobe", {15'd0, hi_strobe}, 16'd0);
        chk("R10 no second read", {15'd0, rd_n}, 16'd1);
        @(posedge clk); #1;
        chk("R10 no second done", {15'd0, done}, 16'd0);
        do_access(1'b0, 16'h70F0, 8'hC3, 1'b0, 2'd0, 1'b0, 1'b0); // R10 cache kept
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk);
        t_reset();
        t_reads();
        t_writes();
        t_gates();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule